// File: doc/BRIEF.md
# Four-Lane Multi-Pattern Payload Matcher

The block scans a packet payload for a small set of configured byte strings. Payload arrives as 32-bit words, four bytes per accepted beat, framed by start and end markers. Each stored string is checked at all four byte offsets inside the word at once. Strings that straddle word boundaries are still found. At the end of each packet the block gives one flag per string, telling whether that string occurred anywhere in the packet.

Each string slot holds up to `PAT_LEN` bytes and one enable bit per byte. The last slot byte is the match anchor. Disabled bytes are don't-cares, so a string shorter than the slot fills the slot's tail. Slots are written one byte at a time through a configuration port. The comparison runs as three register stages: window capture, alignment compare, and per-packet collection.

Top module: `str_cmp_top`

## Requirements
- R1: Each beat with `in_valid_i` high carries four stream bytes. Lane k sits in bits [8k+7:8k], and lane 0 comes first in stream order. Data on cycles with `in_valid_i` low is ignored.
- R2: A write with `cfg_we_i` high sets byte `cfg_pos_i` of slot `cfg_sel_i` to `cfg_byte_i` and its enable to `cfg_en_i`. A slot of length L matches with its last byte at stream position t when every enabled slot byte j equals stream byte t-(L-1)+j. Disabled positions are don't-cares and need not lie inside the packet.
- R3: A match is found at each of the four lane positions of the anchor byte, including strings that span two or more beats.
- R4: A start-of-packet beat clears all earlier stream bytes and the per-packet result, so no match combines bytes of two packets.
- R5: On the end-of-packet beat, `in_keep_i` bit k marks lane k valid, with valid lanes contiguous from lane 0. An invalid lane never counts as a compared byte or as a match anchor. On other beats `in_keep_i` is ignored.
- R6: If the end-of-packet beat is accepted at clock edge n, `match_valid_o` is high for exactly the cycle after edge n+2. At that time `match_o` bit p is set exactly when slot p matched anywhere in that packet. Back-to-back packets are each reported.
- R7: A slot with no enabled byte never matches.
- R8: After reset, `match_valid_o` and `match_o` are 0 and every slot has all enables cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Slot byte write strobe |
| cfg_sel_i | input | SEL_W | Slot index for the write |
| cfg_pos_i | input | POS_W | Byte position within the slot |
| cfg_byte_i | input | 8 | Byte value to store |
| cfg_en_i | input | 1 | Enable bit for that byte |
| in_valid_i | input | 1 | Payload beat valid |
| in_sop_i | input | 1 | Beat is the first of a packet |
| in_eop_i | input | 1 | Beat is the last of a packet |
| in_data_i | input | 32 | Four payload bytes, lane 0 in the low byte |
| in_keep_i | input | 4 | Valid lanes on the last beat |
| match_valid_o | output | 1 | One-cycle pulse carrying a packet result |
| match_o | output | NUM_PAT | Per-slot match flags for the finished packet |

## Verification
Two functions can fall in the same cycle. The collection stage can report one packet's end while it also clears and starts the next packet. The window stage can take a start-of-packet beat while the previous packet's last bytes are still in its history. Zero-gap packets drive both overlaps: a packet's tail and the next packet's head are filled so that, together, they would form a configured string. Each report is judged against a vector computed per packet from the bench's own string model. The bench also checks the exact reporting cycle, so a result leaking across packets, or a clear landing one beat late, shows up as a flag or timing mismatch.

// File: rtl/str_cmp_pkg.sv
package str_cmp_pkg;
  localparam int unsigned LANES  = 4;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned WORD_W = LANES * BYTE_W;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/str_cmp_pat_store.sv
module str_cmp_pat_store
  import str_cmp_pkg::*;
#(
  parameter int unsigned NUM_PAT = 4,
  parameter int unsigned PAT_LEN = 16,
  parameter int unsigned SEL_W   = 2,
  parameter int unsigned POS_W   = 4
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                we_i,
  input  logic [SEL_W-1:0]                    sel_i,
  input  logic [POS_W-1:0]                    pos_i,
  input  byte_t                               byte_i,
  input  logic                                en_i,
  output logic [NUM_PAT-1:0][PAT_LEN-1:0][7:0] pat_o,
  output logic [NUM_PAT-1:0][PAT_LEN-1:0]      en_o,
  output logic [NUM_PAT-1:0]                   any_en_o
);

  logic wr_ok;
  assign wr_ok = we_i && (int'(sel_i) < NUM_PAT) && (int'(pos_i) < PAT_LEN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pat_o <= '0;
      en_o  <= '0;
    end else if (wr_ok) begin
      pat_o[sel_i][pos_i] <= byte_i;
      en_o[sel_i][pos_i]  <= en_i;
    end
  end

  for (genvar p = 0; p < NUM_PAT; p++) begin : g_any
    assign any_en_o[p] = |en_o[p];
  end

  // R2: a write lands at the addressed slot byte
  a_r2_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ok |=> (pat_o[$past(sel_i)][$past(pos_i)] == $past(byte_i)) &&
              (en_o[$past(sel_i)][$past(pos_i)] == $past(en_i)));

endmodule

// File: rtl/str_cmp_window.sv
module str_cmp_window
  import str_cmp_pkg::*;
#(
  parameter int unsigned PAT_LEN = 16,
  parameter int unsigned WIN     = PAT_LEN - 1 + LANES
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic                     sop_i,
  input  logic                     eop_i,
  input  logic [WORD_W-1:0]        data_i,
  input  logic [LANES-1:0]         keep_i,
  output logic [WIN-1:0][7:0]      win_o,
  output logic [WIN-1:0]           vld_o,
  output logic                     s1_vld_o,
  output logic                     s1_sop_o,
  output logic                     s1_eop_o
);

  localparam int unsigned HIST = PAT_LEN - 1;

  logic [WIN-1:0][7:0] win_q, nxt_win;
  logic [WIN-1:0]      vld_q, nxt_vld;

  // window index 0 is the oldest byte; the newest word fills the top lanes
  always_comb begin
    for (int i = 0; i < HIST; i++) begin
      nxt_win[i] = win_q[LANES + i];
      nxt_vld[i] = vld_q[LANES + i] & ~sop_i;
    end
    for (int k = 0; k < LANES; k++) begin
      nxt_win[HIST + k] = data_i[BYTE_W*k +: BYTE_W];
      nxt_vld[HIST + k] = eop_i ? keep_i[k] : 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q    <= '0;
      vld_q    <= '0;
      s1_vld_o <= 1'b0;
      s1_sop_o <= 1'b0;
      s1_eop_o <= 1'b0;
    end else begin
      s1_vld_o <= valid_i;
      s1_sop_o <= valid_i & sop_i;
      s1_eop_o <= valid_i & eop_i;
      if (valid_i) begin
        win_q <= nxt_win;
        vld_q <= nxt_vld;
      end
    end
  end

  assign win_o = win_q;
  assign vld_o = vld_q;

  // R1: idle cycles leave the byte window untouched
  a_r1_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(win_q) && $stable(vld_q));

  // R4: a start beat wipes all history bytes
  a_r4_sop_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && sop_i) |=> (vld_q[HIST-1:0] == '0));

  // R5: keep has no effect on beats other than the last
  a_r5_mid_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !eop_i) |=> (&vld_q[WIN-1:HIST]));

endmodule

// File: rtl/str_cmp_match_array.sv
module str_cmp_match_array
  import str_cmp_pkg::*;
#(
  parameter int unsigned NUM_PAT = 4,
  parameter int unsigned PAT_LEN = 16,
  parameter int unsigned WIN     = PAT_LEN - 1 + LANES
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic [WIN-1:0][7:0]                  win_i,
  input  logic [WIN-1:0]                       vld_i,
  input  logic                                 s1_vld_i,
  input  logic                                 s1_sop_i,
  input  logic                                 s1_eop_i,
  input  logic [NUM_PAT-1:0][PAT_LEN-1:0][7:0] pat_i,
  input  logic [NUM_PAT-1:0][PAT_LEN-1:0]      en_i,
  input  logic [NUM_PAT-1:0]                   any_en_i,
  output logic [NUM_PAT-1:0][LANES-1:0]        hit_o,
  output logic                                 s2_vld_o,
  output logic                                 s2_sop_o,
  output logic                                 s2_eop_o
);

  for (genvar p = 0; p < NUM_PAT; p++) begin : g_pat
    for (genvar a = 0; a < LANES; a++) begin : g_align
      logic hit_c;

      // anchor at window index PAT_LEN-1+a; slot byte j sits at a+j
      always_comb begin
        logic ok;
        ok = 1'b1;
        for (int j = 0; j < PAT_LEN; j++) begin
          if (en_i[p][j] && !(vld_i[a+j] && (win_i[a+j] == pat_i[p][j])))
            ok = 1'b0;
        end
        hit_c = ok & vld_i[PAT_LEN-1+a] & any_en_i[p];
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) hit_o[p][a] <= 1'b0;
        else         hit_o[p][a] <= s1_vld_i & hit_c;
      end

      // R5: an invalid lane is never an anchor
      a_r5_anchor_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s1_vld_i && !vld_i[PAT_LEN-1+a]) |=> !hit_o[p][a]);

      // R7: an empty slot never hits
      a_r7_empty_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !any_en_i[p] |=> !hit_o[p][a]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s2_vld_o <= 1'b0;
      s2_sop_o <= 1'b0;
      s2_eop_o <= 1'b0;
    end else begin
      s2_vld_o <= s1_vld_i;
      s2_sop_o <= s1_sop_i;
      s2_eop_o <= s1_eop_i;
    end
  end

endmodule

// File: rtl/str_cmp_collect.sv
module str_cmp_collect
  import str_cmp_pkg::*;
#(
  parameter int unsigned NUM_PAT = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          vld_i,
  input  logic                          sop_i,
  input  logic                          eop_i,
  input  logic [NUM_PAT-1:0][LANES-1:0] hit_i,
  output logic                          match_valid_o,
  output logic [NUM_PAT-1:0]            match_o
);

  logic [NUM_PAT-1:0] acc_q, nxt_acc;

  always_comb begin
    nxt_acc = sop_i ? '0 : acc_q;
    for (int p = 0; p < NUM_PAT; p++) nxt_acc[p] = nxt_acc[p] | (|hit_i[p]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q         <= '0;
      match_o       <= '0;
      match_valid_o <= 1'b0;
    end else begin
      match_valid_o <= vld_i & eop_i;
      if (vld_i) begin
        if (eop_i) begin
          match_o <= nxt_acc;
          acc_q   <= '0;
        end else begin
          acc_q   <= nxt_acc;
        end
      end
    end
  end

  // R6: a report only follows a last beat leaving the compare stage
  a_r6_report_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_valid_o |-> $past(vld_i && eop_i));

  // R4: a start beat drops hits from before it
  a_r4_acc_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && sop_i && !eop_i && (hit_i == '0)) |=> (acc_q == '0));

endmodule

// File: rtl/str_cmp_top.sv
module str_cmp_top
  import str_cmp_pkg::*;
#(
  parameter int unsigned NUM_PAT = 4,
  parameter int unsigned PAT_LEN = 16,
  localparam int unsigned SEL_W  = (NUM_PAT > 1) ? $clog2(NUM_PAT) : 1,
  localparam int unsigned POS_W  = $clog2(PAT_LEN)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [SEL_W-1:0]   cfg_sel_i,
  input  logic [POS_W-1:0]   cfg_pos_i,
  input  logic [7:0]         cfg_byte_i,
  input  logic               cfg_en_i,
  input  logic               in_valid_i,
  input  logic               in_sop_i,
  input  logic               in_eop_i,
  input  logic [31:0]        in_data_i,
  input  logic [3:0]         in_keep_i,
  output logic               match_valid_o,
  output logic [NUM_PAT-1:0] match_o
);

  localparam int unsigned WIN = PAT_LEN - 1 + LANES;

  logic [NUM_PAT-1:0][PAT_LEN-1:0][7:0] pat;
  logic [NUM_PAT-1:0][PAT_LEN-1:0]      en;
  logic [NUM_PAT-1:0]                   any_en;
  logic [WIN-1:0][7:0]                  win;
  logic [WIN-1:0]                       wvld;
  logic                                 s1_vld, s1_sop, s1_eop;
  logic                                 s2_vld, s2_sop, s2_eop;
  logic [NUM_PAT-1:0][LANES-1:0]        hit;

  str_cmp_pat_store #(
    .NUM_PAT(NUM_PAT), .PAT_LEN(PAT_LEN), .SEL_W(SEL_W), .POS_W(POS_W)
  ) u_store (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .sel_i(cfg_sel_i), .pos_i(cfg_pos_i),
    .byte_i(cfg_byte_i), .en_i(cfg_en_i),
    .pat_o(pat), .en_o(en), .any_en_o(any_en)
  );

  str_cmp_window #(.PAT_LEN(PAT_LEN), .WIN(WIN)) u_win (
    .clk_i, .rst_ni,
    .valid_i(in_valid_i), .sop_i(in_sop_i), .eop_i(in_eop_i),
    .data_i(in_data_i), .keep_i(in_keep_i),
    .win_o(win), .vld_o(wvld),
    .s1_vld_o(s1_vld), .s1_sop_o(s1_sop), .s1_eop_o(s1_eop)
  );

  str_cmp_match_array #(.NUM_PAT(NUM_PAT), .PAT_LEN(PAT_LEN), .WIN(WIN)) u_cmp (
    .clk_i, .rst_ni,
    .win_i(win), .vld_i(wvld),
    .s1_vld_i(s1_vld), .s1_sop_i(s1_sop), .s1_eop_i(s1_eop),
    .pat_i(pat), .en_i(en), .any_en_i(any_en),
    .hit_o(hit), .s2_vld_o(s2_vld), .s2_sop_o(s2_sop), .s2_eop_o(s2_eop)
  );

  str_cmp_collect #(.NUM_PAT(NUM_PAT)) u_col (
    .clk_i, .rst_ni,
    .vld_i(s2_vld), .sop_i(s2_sop), .eop_i(s2_eop), .hit_i(hit),
    .match_valid_o, .match_o
  );

  // R6: fixed distance from last beat to report
  a_r6_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_eop_i) |=> ##2 match_valid_o);

  // R6: reports are single-cycle pulses when last beats are spaced apart
  a_r6_no_stray: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_valid_i || !in_eop_i) |=> ##2 !match_valid_o);

endmodule

// File: tb/str_cmp_top_tb_top.sv
module str_cmp_top_tb_top;
  localparam int NP = 4;
  localparam int PL = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [3:0]  cfg_pos = '0;
  logic [7:0]  cfg_byte = '0;
  logic        cfg_en = 1'b0;
  logic        in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
  logic [31:0] in_data = '0;
  logic [3:0]  in_keep = '0;
  logic        match_valid;
  logic [NP-1:0] match;

  always #2 clk = ~clk;

  str_cmp_top #(.NUM_PAT(NP), .PAT_LEN(PL)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_pos_i(cfg_pos),
    .cfg_byte_i(cfg_byte), .cfg_en_i(cfg_en),
    .in_valid_i(in_valid), .in_sop_i(in_sop), .in_eop_i(in_eop),
    .in_data_i(in_data), .in_keep_i(in_keep),
    .match_valid_o(match_valid), .match_o(match)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [7:0] pm_b [NP][PL];
  bit         pm_e [NP][PL];
  logic [7:0] pkt [$];
  logic [7:0] pad [$];
  logic [NP-1:0] exp_q [$];
  int            due_q [$];
  string         tag_q [$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) if (cyc > 150000) begin
    n_chk++; n_bad++;
    $display("FAIL watchdog: act=running exp=done");
    summary();
  end

  // output monitor: R6 timing and flags
  always @(negedge clk) if (rst_n) begin
    if (match_valid) begin
      n_chk++;
      if (due_q.size() == 0 || due_q[0] != cyc) begin
        n_bad++;
        $display("FAIL R6 stray report: act=pulse@%0d exp=%0d", cyc,
                 (due_q.size() != 0) ? due_q[0] : -1);
      end else begin
        if (match !== exp_q[0]) begin
          n_bad++;
          $display("FAIL %s flags: act=%b exp=%b", tag_q[0], match, exp_q[0]);
        end
        void'(exp_q.pop_front()); void'(due_q.pop_front()); void'(tag_q.pop_front());
      end
    end else if (due_q.size() != 0 && due_q[0] == cyc) begin
      n_chk++; n_bad++;
      $display("FAIL R6 missing report (%s): act=none exp=%b", tag_q[0], exp_q[0]);
      void'(exp_q.pop_front()); void'(due_q.pop_front()); void'(tag_q.pop_front());
    end
  end

  function automatic logic [7:0] rnd_ch();
    return 8'h41 + 8'($urandom_range(0, 3));
  endfunction

  function automatic logic [NP-1:0] model();
    logic [NP-1:0] r = '0;
    int n = pkt.size();
    for (int p = 0; p < NP; p++) begin
      bit any = 0;
      for (int j = 0; j < PL; j++) any |= pm_e[p][j];
      if (!any) continue;
      for (int t = 0; t < n; t++) begin
        bit ok = 1;
        for (int j = 0; j < PL; j++) if (pm_e[p][j]) begin
          int pos = t - (PL - 1) + j;
          if (pos < 0 || pkt[pos] != pm_b[p][j]) ok = 0;
        end
        if (ok) r[p] = 1'b1;
      end
    end
    return r;
  endfunction

  task automatic cfg_wr(int s, int p, logic [7:0] b, bit e);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'(s); cfg_pos = 4'(p); cfg_byte = b; cfg_en = e;
    pm_b[s][p] = b; pm_e[s][p] = e;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic gen_fill(int n, bit rnd, logic [7:0] ch);
    pkt.delete();
    for (int i = 0; i < n; i++) pkt.push_back(rnd ? rnd_ch() : ch);
  endtask

  // place slot s so its anchor lands at stream position e
  task automatic embed(int s, int e);
    for (int j = 0; j < PL; j++) if (pm_e[s][j]) begin
      int pos = e - (PL - 1) + j;
      if (pos >= 0 && pos < pkt.size()) pkt[pos] = pm_b[s][j];
    end
  endtask

  task automatic drive(string tag, int idle_max);
    int n = pkt.size();
    int nw = (n + 3) / 4;
    logic [NP-1:0] e = model();
    for (int w = 0; w < nw; w++) begin
      int idl = (idle_max > 0) ? $urandom_range(0, idle_max) : 0;
      for (int k = 0; k < idl; k++) begin
        @(negedge clk);
        in_valid = 1'b0; in_sop = $urandom_range(0, 1); in_eop = $urandom_range(0, 1);
        in_data = $urandom(); in_keep = 4'($urandom());
      end
      @(negedge clk);
      in_valid = 1'b1; in_sop = (w == 0); in_eop = (w == nw - 1);
      for (int k = 0; k < 4; k++) begin
        int idx = 4 * w + k;
        in_data[8*k +: 8] = (idx < n) ? pkt[idx] :
                            ((idx - n < pad.size()) ? pad[idx - n] : rnd_ch());
      end
      if (w == nw - 1) begin
        int rem = n - 4 * w;
        in_keep = 4'((1 << rem) - 1);
        exp_q.push_back(e); due_q.push_back(cyc + 3); tag_q.push_back(tag);
      end else begin
        in_keep = 4'($urandom());
      end
    end
    pad.delete();
  endtask

  task automatic go_idle(int c);
    for (int i = 0; i < c; i++) begin
      @(negedge clk);
      in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    end
  endtask

  initial begin
    void'($urandom(32'h1f2e3d4c));
    for (int p = 0; p < NP; p++) for (int j = 0; j < PL; j++) begin
      pm_b[p][j] = '0; pm_e[p][j] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    n_chk++;
    if (match_valid !== 1'b0 || match !== '0) begin
      n_bad++;
      $display("FAIL R8 reset outputs: act=%b/%b exp=0/0", match_valid, match);
    end

    // R8 / R7: no slot enabled after reset, a packet full of letters reports 0
    gen_fill(12, 1, 8'h0); drive("R8", 0); go_idle(4);

    // slot 0: full 16 bytes; slot 1: "ABC" in the tail; slot 2: sparse mask
    for (int j = 0; j < PL; j++) cfg_wr(0, j, rnd_ch(), 1);
    for (int j = 0; j < PL; j++) cfg_wr(1, j, 8'h44, 0);
    cfg_wr(1, 13, 8'h41, 1); cfg_wr(1, 14, 8'h42, 1); cfg_wr(1, 15, 8'h43, 1);
    cfg_wr(2, 8, 8'h42, 1); cfg_wr(2, 11, 8'h44, 1); cfg_wr(2, 15, 8'h41, 1);

    // R3: full slot anchored on each lane, spanning beats
    for (int a = 0; a < 4; a++) begin
      gen_fill(28, 0, 8'h44); embed(0, 16 + a); drive("R3", 0); go_idle(3);
    end
    // R2: don't-care head lies before packet start
    gen_fill(3, 0, 8'h44); embed(1, 2); drive("R2", 0); go_idle(3);
    // R6: single-beat packet
    gen_fill(3, 0, 8'h41); embed(1, 2); drive("R6", 0); go_idle(3);
    // R4: tail "AB" then next packet opens with "C", back to back
    gen_fill(8, 0, 8'h44); pkt[6] = 8'h41; pkt[7] = 8'h42; drive("R4", 0);
    gen_fill(8, 0, 8'h44); pkt[0] = 8'h43; drive("R4", 0); go_idle(4);
    // R5: "ABC" completed only on lanes dropped by keep
    gen_fill(6, 0, 8'h44); pkt[5] = 8'h41; pad.push_back(8'h42); pad.push_back(8'h43);
    drive("R5", 0); go_idle(3);
    // R5: same end, keep admits all lanes
    gen_fill(8, 0, 8'h44); pkt[5] = 8'h41; pkt[6] = 8'h42; pkt[7] = 8'h43;
    drive("R5", 0); go_idle(3);
    // R1: idle beats carrying junk between words
    gen_fill(30, 0, 8'h44); embed(0, 25); drive("R1", 3); go_idle(4);
    // R7 then R2: slot 3 empty, then given "DDA" and later emptied again
    gen_fill(10, 0, 8'h44); pkt[9] = 8'h41; drive("R7", 0); go_idle(3);
    cfg_wr(3, 13, 8'h44, 1); cfg_wr(3, 14, 8'h44, 1); cfg_wr(3, 15, 8'h41, 1);
    gen_fill(10, 0, 8'h44); pkt[9] = 8'h41; drive("R2", 0); go_idle(3);
    cfg_wr(3, 13, 8'h44, 0); cfg_wr(3, 14, 8'h44, 0); cfg_wr(3, 15, 8'h41, 0);
    gen_fill(10, 0, 8'h44); pkt[9] = 8'h41; drive("R7", 0); go_idle(3);

    // random traffic, zero-gap or short gaps
    for (int i = 0; i < 400; i++) begin
      int n = $urandom_range(1, 40);
      gen_fill(n, 1, 8'h0);
      if ($urandom_range(0, 2) == 0) embed(0, $urandom_range(0, n - 1));
      drive("R6", $urandom_range(0, 1));
      if ($urandom_range(0, 3) == 0) go_idle($urandom_range(1, 3));
    end
    go_idle(10);
    n_chk++;
    if (due_q.size() != 0) begin
      n_bad++;
      $display("FAIL R6 pending reports: act=%0d exp=0", due_q.size());
    end
    summary();
  end
endmodule